// File: doc/BRIEF.md
# Extended Data RAM Access Controller

This block answers byte-wide accesses that a CPU makes to its external data space. It contains a 512-byte on-chip RAM that appears at the bottom of that space. Every access that falls outside the RAM's active window goes to an external bus, which has an address, write data, read data and separate read and write strobes. The CPU can address the space in two ways. A 16-bit pointer gives the full address. An 8-bit pointer gives the low byte, and a page input supplies the high byte.

Three configuration inputs shape the routing and the timing:
- A force-external bit sends every access to the bus.
- A window-size bit chooses between 256 and 512 bytes of visible on-chip RAM. When the window is small, addresses 100h to 1FFh go to the bus.
- A stretch bit widens the external strobe from 6 to 30 clocks, for slow devices.

The controller reads the configuration once, when it accepts an access. It works on one access at a time and reports completion with a one-cycle done pulse.

Top module: `xram_access_ctrl`

## Requirements
- R1: During and after synchronous reset, rsp_busy, rsp_done, ext_rd and ext_wr are 0, and rsp_rdata and ext_addr are 0.
- R2: With cfg_force_ext=0 and cfg_big_win=0, addresses 0000h to 00FFh are served by on-chip RAM. Addresses 0100h and above go to the external bus.
- R3: With cfg_force_ext=0 and cfg_big_win=1, addresses 0000h to 01FFh are served by on-chip RAM, and 0200h and above go external. Data written while the window was large stays in the RAM while it is hidden, and can be read again once the window is large.
- R4: With cfg_force_ext=1, every access goes to the external bus, whatever its address.
- R5: When req_wide=1, the address is req_ptr16. When req_wide=0, the address is {req_page, req_ptr8}. For example, page 00h with pointer A0h reaches on-chip RAM at 00A0h.
- R6: An access to on-chip RAM never raises rsp_busy or a strobe. rsp_done is high in the cycle right after the accepting edge, and for a read rsp_rdata holds the stored byte in that same cycle.
- R7: With cfg_slow=0, an external access holds exactly one strobe high for 6 consecutive cycles. rsp_busy is high for those same 6 cycles, and rsp_done pulses in the next cycle.
- R8: With cfg_slow=1, the strobe and rsp_busy last 30 cycles.
- R9: During an external access, ext_addr holds the access address for the whole strobe. A write raises only ext_wr, with ext_wdata steady. A read raises only ext_rd, and rsp_rdata shows the ext_rdata value sampled on the last strobe cycle.
- R10: A change to the cfg_* inputs after an access has been accepted does not change that access's routing or strobe width.
- R11: A request is accepted only while rsp_busy is 0. A request raised while busy causes no access, no RAM write and no done pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Access request, taken on an edge where rsp_busy is 0 |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wide | input | 1 | 1 = use the 16-bit pointer, 0 = page plus 8-bit pointer |
| req_ptr16 | input | 16 | Full 16-bit address |
| req_ptr8 | input | 8 | Low address byte in 8-bit pointer mode |
| req_page | input | 8 | High address byte in 8-bit pointer mode |
| req_wdata | input | 8 | Write data |
| cfg_force_ext | input | 1 | 1 = route every access to the external bus |
| cfg_big_win | input | 1 | 0 = 256-byte window, 1 = 512-byte window |
| cfg_slow | input | 1 | 0 = 6-cycle strobe, 1 = 30-cycle strobe |
| rsp_rdata | output | 8 | Read data, valid with rsp_done after a read |
| rsp_busy | output | 1 | High while an external access is in progress |
| rsp_done | output | 1 | One-cycle completion pulse |
| ext_addr | output | 16 | External bus address |
| ext_wdata | output | 8 | External bus write data |
| ext_rdata | input | 8 | External bus read data |
| ext_rd | output | 1 | External read strobe, active high |
| ext_wr | output | 1 | External write strobe, active high |

## Verification
The assertions rely on these input rules:
- The requester raises req_valid only while rsp_busy is low, or keeps it raised until done.
- ext_rdata is settled by the last strobe cycle.
- The cfg_* inputs are plain levels, with no relation to any access in flight.

The stimulus drives every request on a falling edge while the block is idle and drops it on the next falling edge. It changes the configuration bits only between accesses, except in the deliberate mid-access change that R10 requires and the hold-off pokes during busy that R11 requires. The external device model is a combinational function of ext_addr, so its read data is always settled before the capture cycle.

// File: rtl/xram_pkg.sv
// Package: shared types for the extended data RAM access controller.
// Assumes: nothing beyond IEEE 1800-2017 enum support.
package xram_pkg;

    // External strobe sequencer states.
    typedef enum logic [0:0] {
        SEQ_IDLE   = 1'b0,
        SEQ_STROBE = 1'b1
    } seq_state_e;

endpackage : xram_pkg

// File: rtl/xram_addr_route.sv
// Module: xram_addr_route
// Forms the 16-bit access address from either the wide pointer or
// page + narrow pointer, then decides whether the on-chip RAM window
// covers it.
// Assumes: ADDR_W is even (page and narrow pointer are each half of it),
// and SMALL_DEPTH <= RAM_DEPTH < 2**ADDR_W.
module xram_addr_route #(
    parameter int ADDR_W      = 16,
    parameter int RAM_DEPTH   = 512,
    parameter int SMALL_DEPTH = 256
) (
    input  logic                  wide,
    input  logic [ADDR_W-1:0]     ptr16,
    input  logic [ADDR_W/2-1:0]   ptr8,
    input  logic [ADDR_W/2-1:0]   page,
    input  logic                  force_ext,
    input  logic                  big_win,
    output logic [ADDR_W-1:0]     full_addr,
    output logic                  hit_int
);

    localparam logic [ADDR_W:0] BIG_LIM   = (ADDR_W+1)'(RAM_DEPTH);
    localparam logic [ADDR_W:0] SMALL_LIM = (ADDR_W+1)'(SMALL_DEPTH);

    logic [ADDR_W:0] win_lim;

    // Select the address source for this access.
    always_comb begin
        full_addr = wide ? ptr16 : {page, ptr8};
    end

    // Compare against the active window limit; force bit overrides.
    always_comb begin
        win_lim = big_win ? BIG_LIM : SMALL_LIM;
        hit_int = !force_ext && ({1'b0, full_addr} < win_lim);
    end

endmodule : xram_addr_route

// File: rtl/xram_store.sv
// Module: xram_store
// Byte-wide on-chip RAM with one synchronous write port and a
// combinational read port. The read value is registered by the caller.
// Assumes: addr is already known to lie inside the RAM.
module xram_store #(
    parameter int DATA_W    = 8,
    parameter int RAM_DEPTH = 512,
    localparam int RAM_AW   = $clog2(RAM_DEPTH)
) (
    input  logic              clk,
    input  logic              we,
    input  logic [RAM_AW-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);

    logic [DATA_W-1:0] mem [RAM_DEPTH];

    // Store a byte on an accepted internal write.
    always_ff @(posedge clk) begin
        if (we) begin
            mem[addr] <= wdata;
        end
    end

    // Present the addressed byte for the caller's read register.
    always_comb begin
        rdata = mem[addr];
    end

endmodule : xram_store

// File: rtl/xram_ext_seq.sv
// Module: xram_ext_seq
// Runs one external bus access. It latches address, data, direction and
// the stretch choice at start, then holds one strobe high for FAST_W or
// SLOW_W cycles. It flags the last strobe cycle so the caller can capture
// read data.
// Assumes: start is raised only while busy is low.
module xram_ext_seq
    import xram_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8,
    parameter int FAST_W = 6,
    parameter int SLOW_W = 30,
    localparam int CNT_W = $clog2(SLOW_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              start_write,
    input  logic              start_slow,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic [DATA_W-1:0] start_wdata,
    output logic              busy,
    output logic              last,
    output logic [ADDR_W-1:0] ext_addr,
    output logic [DATA_W-1:0] ext_wdata,
    output logic              ext_rd,
    output logic              ext_wr
);

    seq_state_e        state_q;
    logic [CNT_W-1:0]  cnt_q;
    logic              wr_q;
    logic              slow_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;

    // State, countdown and latched access fields.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SEQ_IDLE;
            cnt_q   <= '0;
            wr_q    <= 1'b0;
            slow_q  <= 1'b0;
            addr_q  <= '0;
            wdata_q <= '0;
        end else begin
            case (state_q)
                SEQ_IDLE: begin
                    if (start) begin
                        state_q <= SEQ_STROBE;
                        cnt_q   <= start_slow ? CNT_W'(SLOW_W - 1) : CNT_W'(FAST_W - 1);
                        wr_q    <= start_write;
                        slow_q  <= start_slow;
                        addr_q  <= start_addr;
                        wdata_q <= start_wdata;
                    end
                end
                SEQ_STROBE: begin
                    if (cnt_q == '0) begin
                        state_q <= SEQ_IDLE;
                    end else begin
                        cnt_q <= cnt_q - 1'b1;
                    end
                end
                default: state_q <= SEQ_IDLE;
            endcase
        end
    end

    // Drive the bus from the latched fields.
    always_comb begin
        busy      = (state_q == SEQ_STROBE);
        last      = busy && (cnt_q == '0);
        ext_rd    = busy && !wr_q;
        ext_wr    = busy && wr_q;
        ext_addr  = addr_q;
        ext_wdata = wdata_q;
    end

    // Checker support: length of the current strobe run.
    logic [CNT_W:0] run_len_q;
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_len_q <= '0;
        end else if (ext_rd || ext_wr) begin
            run_len_q <= run_len_q + 1'b1;
        end else begin
            run_len_q <= '0;
        end
    end

    assert_strobe_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ext_rd, ext_wr}));

    assert_addr_steady_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> ($stable(ext_addr) && $stable(ext_wdata)));

    // R7 / R8: a finished strobe lasted the width chosen at its start.
    assert_strobe_width_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (run_len_q == (slow_q ? (CNT_W+1)'(SLOW_W) : (CNT_W+1)'(FAST_W))));

    assert_no_restart_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !last) |=> busy);

endmodule : xram_ext_seq

// File: rtl/xram_access_ctrl.sv
// Module: xram_access_ctrl (top)
// Accepts one external-data-space byte access at a time. It routes the
// access to on-chip RAM (one cycle) or to the external bus (stretched
// strobe). It returns read data together with a one-cycle done pulse.
// Assumes: the requester holds or re-raises req_valid until it is taken
// while rsp_busy is low.
module xram_access_ctrl #(
    parameter int ADDR_W      = 16,
    parameter int DATA_W      = 8,
    parameter int RAM_DEPTH   = 512,
    parameter int SMALL_DEPTH = 256,
    parameter int FAST_W      = 6,
    parameter int SLOW_W      = 30,
    localparam int RAM_AW     = $clog2(RAM_DEPTH),
    localparam int PTR_W      = ADDR_W / 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic              req_wide,
    input  logic [ADDR_W-1:0] req_ptr16,
    input  logic [PTR_W-1:0]  req_ptr8,
    input  logic [PTR_W-1:0]  req_page,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              cfg_force_ext,
    input  logic              cfg_big_win,
    input  logic              cfg_slow,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              rsp_busy,
    output logic              rsp_done,
    output logic [ADDR_W-1:0] ext_addr,
    output logic [DATA_W-1:0] ext_wdata,
    input  logic [DATA_W-1:0] ext_rdata,
    output logic              ext_rd,
    output logic              ext_wr
);

    logic [ADDR_W-1:0] full_addr;
    logic              hit_int;
    logic              acc_go;
    logic              int_go;
    logic              ext_go;
    logic              seq_busy;
    logic              seq_last;
    logic [DATA_W-1:0] int_rdata;

    xram_addr_route #(
        .ADDR_W      (ADDR_W),
        .RAM_DEPTH   (RAM_DEPTH),
        .SMALL_DEPTH (SMALL_DEPTH)
    ) i_route (
        .wide      (req_wide),
        .ptr16     (req_ptr16),
        .ptr8      (req_ptr8),
        .page      (req_page),
        .force_ext (cfg_force_ext),
        .big_win   (cfg_big_win),
        .full_addr (full_addr),
        .hit_int   (hit_int)
    );

    // Accept only while idle; split by destination.
    always_comb begin
        acc_go = req_valid && !seq_busy;
        int_go = acc_go && hit_int;
        ext_go = acc_go && !hit_int;
    end

    xram_store #(
        .DATA_W    (DATA_W),
        .RAM_DEPTH (RAM_DEPTH)
    ) i_store (
        .clk   (clk),
        .we    (int_go && req_write),
        .addr  (full_addr[RAM_AW-1:0]),
        .wdata (req_wdata),
        .rdata (int_rdata)
    );

    xram_ext_seq #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .FAST_W (FAST_W),
        .SLOW_W (SLOW_W)
    ) i_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (ext_go),
        .start_write (req_write),
        .start_slow  (cfg_slow),
        .start_addr  (full_addr),
        .start_wdata (req_wdata),
        .busy        (seq_busy),
        .last        (seq_last),
        .ext_addr    (ext_addr),
        .ext_wdata   (ext_wdata),
        .ext_rd      (ext_rd),
        .ext_wr      (ext_wr)
    );

    // Completion pulse and read data register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_done  <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_done <= int_go || seq_last;
            if (int_go && !req_write) begin
                rsp_rdata <= int_rdata;
            end else if (seq_last && ext_rd) begin
                rsp_rdata <= ext_rdata;
            end
        end
    end

    // Expose the sequencer's busy flag.
    always_comb begin
        rsp_busy = seq_busy;
    end

    assert_int_one_cycle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        int_go |=> (rsp_done && !rsp_busy && !ext_rd && !ext_wr));

    assert_force_ext_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_go && cfg_force_ext) |=> rsp_busy);

    assert_done_after_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rsp_busy) |-> rsp_done);

    assert_done_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |-> !rsp_busy);

endmodule : xram_access_ctrl

// File: tb/test_xram_access_ctrl.sv
// Scoreboard bench: the driver task pushes one expected item per access.
// A monitor on the falling edge measures the strobe and busy lengths and
// the latency, then pops and compares on rsp_done.
module test_xram_access_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0, req_wide = 1'b0;
    logic [15:0] req_ptr16 = '0;
    logic [7:0]  req_ptr8 = '0, req_page = '0, req_wdata = '0;
    logic        cfg_force_ext = 1'b0, cfg_big_win = 1'b0, cfg_slow = 1'b0;
    logic [7:0]  rsp_rdata;
    logic        rsp_busy, rsp_done;
    logic [15:0] ext_addr;
    logic [7:0]  ext_wdata, ext_rdata;
    logic        ext_rd, ext_wr;

    always #2.5 clk = ~clk;  // 200 MHz

    xram_access_ctrl i_xram_access_ctrl (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_wide(req_wide), .req_ptr16(req_ptr16), .req_ptr8(req_ptr8),
        .req_page(req_page), .req_wdata(req_wdata), .cfg_force_ext(cfg_force_ext),
        .cfg_big_win(cfg_big_win), .cfg_slow(cfg_slow), .rsp_rdata(rsp_rdata),
        .rsp_busy(rsp_busy), .rsp_done(rsp_done), .ext_addr(ext_addr),
        .ext_wdata(ext_wdata), .ext_rdata(ext_rdata), .ext_rd(ext_rd), .ext_wr(ext_wr)
    );

    // External device model: read data is a fixed function of the address.
    function automatic logic [7:0] dev_val(input logic [15:0] a);
        return a[7:0] ^ a[15:8] ^ 8'h5A;
    endfunction
    assign ext_rdata = dev_val(ext_addr);

    typedef struct {
        string       tag;
        bit          is_ext;
        bit          wr;
        int          width;
        logic [15:0] addr;
        logic [7:0]  wdata;
        logic [7:0]  rdata;
        int          acc_cyc;
    } item_t;

    item_t       sb_q[$];
    logic [7:0]  shadow [512];
    int          n_checks = 0, n_fail = 0, cyc = 0;
    int          strb_cnt = 0, busy_cnt = 0;
    logic [15:0] seen_addr = '0;
    logic [7:0]  seen_wd = '0;
    bit          seen_wr = 0, seen_rd = 0;

    task automatic check(input string tag, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    always @(posedge clk) cyc <= cyc + 1;

    // Monitor: measure each access, then compare on done.
    always @(negedge clk) begin
        if (rst_n) begin
            if (ext_rd || ext_wr) begin
                strb_cnt++;
                seen_addr = ext_addr;
                if (ext_wr) begin seen_wr = 1; seen_wd = ext_wdata; end
                if (ext_rd) seen_rd = 1;
            end
            if (rsp_busy) busy_cnt++;
            if (rsp_done) begin
                if (sb_q.size() == 0) begin
                    check("R11", "unexpected done", 1, 0);
                end else begin
                    item_t it;
                    it = sb_q.pop_front();
                    check(it.tag, "strobe cycles", strb_cnt, it.width);
                    check(it.tag, "busy cycles", busy_cnt, it.width);
                    check(it.tag, "done latency", cyc - it.acc_cyc, it.width);
                    if (it.is_ext) begin
                        check(it.tag, "ext addr", seen_addr, it.addr);
                        check(it.tag, "wr strobe", seen_wr, it.wr);
                        check(it.tag, "rd strobe", seen_rd, !it.wr);
                        if (it.wr) check(it.tag, "ext wdata", seen_wd, it.wdata);
                    end
                    if (!it.wr) check(it.tag, "rdata", rsp_rdata, it.rdata);
                end
                strb_cnt = 0; busy_cnt = 0; seen_wr = 0; seen_rd = 0;
            end
        end
    end

    // Driver: issue one access at a falling edge and push its expectation.
    task automatic issue(input string tag, input bit wr, input bit wide,
                         input logic [15:0] p16, input logic [7:0] pg,
                         input logic [7:0] p8, input logic [7:0] wd);
        item_t it;
        logic [15:0] a;
        a = wide ? p16 : {pg, p8};
        it.tag     = tag;
        it.wr      = wr;
        it.addr    = a;
        it.wdata   = wd;
        it.is_ext  = cfg_force_ext || (a >= (cfg_big_win ? 16'd512 : 16'd256));
        it.width   = it.is_ext ? (cfg_slow ? 30 : 6) : 0;
        it.rdata   = it.is_ext ? dev_val(a) : shadow[a[8:0]];
        if (!it.is_ext && wr) shadow[a[8:0]] = wd;
        @(negedge clk);
        it.acc_cyc = cyc + 1;
        sb_q.push_back(it);
        req_valid = 1; req_write = wr; req_wide = wide;
        req_ptr16 = p16; req_page = pg; req_ptr8 = p8; req_wdata = wd;
        @(negedge clk);
        req_valid = 0;
    endtask

    task automatic drain();
        while (sb_q.size() != 0) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic acc(input string tag, input bit wr, input bit wide,
                       input logic [15:0] p16, input logic [7:0] pg,
                       input logic [7:0] p8, input logic [7:0] wd);
        issue(tag, wr, wide, p16, pg, p8, wd);
        drain();
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (100000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: outputs in reset
        check("R1", "busy", rsp_busy, 0);
        check("R1", "done", rsp_done, 0);
        check("R1", "strobes", {ext_rd, ext_wr}, 0);
        check("R1", "rdata", rsp_rdata, 0);
        check("R1", "ext_addr", ext_addr, 0);
        rst_n = 1;
        @(negedge clk);
        check("R1", "busy after reset", rsp_busy, 0);

        // R2 / R6: small window, internal accesses
        acc("R6", 1, 1, 16'h0010, 8'h00, 8'h00, 8'h3C);
        acc("R6", 0, 1, 16'h0010, 8'h00, 8'h00, 8'h00);
        acc("R2", 1, 1, 16'h00FF, 8'h00, 8'h00, 8'h99);
        acc("R2", 0, 1, 16'h00FF, 8'h00, 8'h00, 8'h00);
        // R5: narrow pointer A0h on page 00h lands in on-chip RAM
        acc("R5", 1, 0, 16'hFFFF, 8'h00, 8'hA0, 8'h77);
        acc("R5", 0, 1, 16'h00A0, 8'h00, 8'h00, 8'h00);
        // R2 / R7 / R9: just past the small window goes external
        acc("R7", 1, 1, 16'h0100, 8'h00, 8'h00, 8'hB4);
        acc("R9", 0, 1, 16'h01FF, 8'h00, 8'h00, 8'h00);

        // R3: large window
        cfg_big_win = 1;
        acc("R3", 1, 1, 16'h0150, 8'h00, 8'h00, 8'hC3);
        acc("R3", 1, 0, 16'h0000, 8'h01, 8'hFF, 8'h11);
        acc("R3", 0, 1, 16'h0150, 8'h00, 8'h00, 8'h00);
        acc("R3", 0, 1, 16'h01FF, 8'h00, 8'h00, 8'h00);
        acc("R3", 0, 1, 16'h0200, 8'h00, 8'h00, 8'h00);
        // R3: hiding keeps the contents
        cfg_big_win = 0;
        acc("R3", 0, 1, 16'h0150, 8'h00, 8'h00, 8'h00);
        cfg_big_win = 1;
        acc("R3", 0, 1, 16'h0150, 8'h00, 8'h00, 8'h00);

        // R4: force external
        cfg_force_ext = 1;
        acc("R4", 0, 1, 16'h0010, 8'h00, 8'h00, 8'h00);
        acc("R5", 0, 0, 16'h0000, 8'h12, 8'h34, 8'h00);
        // R8: stretched strobes
        cfg_slow = 1;
        acc("R8", 1, 1, 16'h0020, 8'h00, 8'h00, 8'h5E);
        acc("R8", 0, 1, 16'h8001, 8'h00, 8'h00, 8'h00);
        cfg_force_ext = 0;
        acc("R4", 0, 1, 16'h0010, 8'h00, 8'h00, 8'h00);

        // R10: configuration changed mid-access has no effect
        cfg_slow = 0; cfg_big_win = 0;
        issue("R10", 0, 1, 16'h0300, 8'h00, 8'h00, 8'h00);
        cfg_slow = 1; cfg_big_win = 1; cfg_force_ext = 1;
        drain();
        cfg_force_ext = 0;
        issue("R10", 0, 1, 16'h0180, 8'h00, 8'h00, 8'h00);
        cfg_slow = 0; cfg_big_win = 0;
        drain();

        // R11: requests while busy are ignored
        cfg_slow = 0; cfg_big_win = 0;
        issue("R11", 0, 1, 16'h0400, 8'h00, 8'h00, 8'h00);
        req_valid = 1; req_write = 1; req_wide = 1; req_ptr16 = 16'h0010; req_wdata = 8'hEE;
        repeat (3) @(negedge clk);
        req_valid = 0;
        drain();
        acc("R11", 0, 1, 16'h0010, 8'h00, 8'h00, 8'h00);

        repeat (4) @(negedge clk);
        check("R11", "pending items", sb_q.size(), 0);
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule : test_xram_access_ctrl